// File: doc/BRIEF.md
# Three-wire serial memory with self-timed word erase

This block is the target end of a three-wire serial memory link: a chip-select input, a serial clock input and a serial data input, plus a data output that can be released to high impedance. A word-organized array lives in registers inside the block. Each instruction opens with a start bit of 1 and carries a two-bit opcode and an address, all sampled on rising serial clock edges. The serial pins are resynchronized to a system clock, and edges are detected in that domain.

An ERASE forces every bit of the chosen word to 1. It runs for a fixed number of system clocks, and while it runs the block takes no further instructions. A parameter selects what launches the erase. In one mode the erase starts when chip select drops after the final address bit. In the other mode it starts on the serial clock edge that samples that bit. After chip select has been low for long enough and then returns high, the data output shows the erase status: 0 while the erase is busy and 1 once it has finished. The status indication stays armed until a start bit is sent and chip select is then dropped. A READ instruction shifts a word out so that software or a bench can confirm the erase.

Top module: `sme_erase_ctrl`

## Requirements
- R1: After reset the output enable is 0, and the word at address a holds (3*a+1) truncated to DATA_W bits.
- R2: A frame is sampled on rising serial clock edges while chip select is high. It consists of a start bit 1, then a two-bit opcode sent high bit first, then ADDR_W address bits sent most significant first. Any 0 bits before the start bit are skipped.
- R3: Opcode 10 (READ) enables the output on the edge that samples the last address bit, with a 0 dummy bit first. Each following rising edge presents the next bit of the word, most significant first. The edge after the last bit releases the output.
- R4: Opcode 11 (ERASE) sets every bit of the addressed word to 1 and leaves all other words unchanged.
- R5: With START_ON_CLK=0, the erase begins when chip select falls after the last address bit.
- R6: With START_ON_CLK=1, the erase begins on the rising edge that samples the last address bit, while chip select is still high.
- R7: The erase stays busy for ERASE_CYCLES system clocks. When chip select rises after at least CSL_MIN clocks low, the output is enabled and shows 0 while busy and 1 once done.
- R8: A chip-select low time shorter than CSL_MIN clocks does not enable the status output.
- R9: A start bit followed by chip select falling, with no erase busy, clears the status indication. The output then stays high impedance on the next chip-select high.
- R10: Frames received while an erase is busy are ignored and change no word.
- R11: Opcodes 00 and 01 change no word and leave the output disabled.
- R12: Outside read data and the status window the output enable is 0, and it is always 0 while chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Serial chip select, active high |
| sclk_i | input | 1 | Serial clock, data sampled on its rising edge |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Drive enable for sdo_o; 0 means high impedance |

## Verification
Every word is read back right after reset, with and without leading zero bits, so the address decode and the dummy-bit framing are covered across the whole array. A small configuration has a mix of words erased, and a full readback then separates the erased words from untouched neighbours. A single erase frame is applied to both start modes at once, and chip select is then held high well past the erase time, so the two variants report opposite status at the first check. Status windows that are too short, cleared, and opened while busy, and frames sent while busy or with unused opcodes, each confirm that the output enable and the array change only when they should.

// File: rtl/sme_pkg.sv
package sme_pkg;

   typedef enum logic [1:0] {
      OP_RSV0  = 2'b00,
      OP_RSV1  = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } sme_op_e;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_OPC,
      FS_ADDR,
      FS_RD,
      FS_DONE
   } sme_fs_e;

endpackage

// File: rtl/sme_pin_sync.sv
module sme_pin_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic di_i,
   output logic cs_o,
   output logic di_o,
   output logic sck_rise_o,
   output logic cs_rise_o,
   output logic cs_fall_o
);

   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] cs_q, sck_q, di_q;
   logic         cs_d, sck_d;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= '0;
         sck_q <= '0;
         di_q  <= '0;
         cs_d  <= 1'b0;
         sck_d <= 1'b0;
      end else begin
         cs_q  <= {cs_q[TOP-1:0], cs_i};
         sck_q <= {sck_q[TOP-1:0], sck_i};
         di_q  <= {di_q[TOP-1:0], di_i};
         cs_d  <= cs_q[TOP];
         sck_d <= sck_q[TOP];
      end
   end

   assign cs_o       = cs_q[TOP];
   assign di_o       = di_q[TOP];
   assign sck_rise_o = sck_q[TOP] & ~sck_d;
   assign cs_rise_o  = cs_q[TOP] & ~cs_d;
   assign cs_fall_o  = ~cs_q[TOP] & cs_d;

endmodule

// File: rtl/sme_frame_rx.sv
module sme_frame_rx
   import sme_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 16,
   parameter bit START_ON_CLK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              di_s,
   input  logic              sck_rise,
   input  logic              cs_fall,
   input  logic              busy,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] look_addr,
   output logic [ADDR_W-1:0] erase_addr,
   output logic              erase_go,
   output logic              rd_active,
   output logic              rd_bit,
   output logic              start_seen
);

   localparam int CW = $clog2(ADDR_W + DATA_W + 2);

   sme_fs_e         fs;
   sme_op_e         op;
   logic [ADDR_W-1:0] addr_sr;
   logic [CW-1:0]     cnt;
   logic [DATA_W:0]   rd_sr;
   logic              erase_pend;
   logic              last_addr;
   logic              fire;

   assign look_addr  = {addr_sr[ADDR_W-2:0], di_s};
   assign erase_addr = addr_sr;
   assign rd_bit     = rd_sr[DATA_W];
   assign last_addr  = cs_s & sck_rise & (fs == FS_ADDR) & (cnt == CW'(ADDR_W - 1));
   assign start_seen = cs_s & sck_rise & (fs == FS_IDLE) & di_s;

   generate
      if (START_ON_CLK) begin : g_clk_start
         assign fire = last_addr & (op == OP_ERASE);
      end else begin : g_cs_start
         assign fire = cs_fall & erase_pend;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs         <= FS_IDLE;
         op         <= OP_RSV0;
         addr_sr    <= '0;
         cnt        <= '0;
         rd_sr      <= '0;
         rd_active  <= 1'b0;
         erase_pend <= 1'b0;
         erase_go   <= 1'b0;
      end else begin
         erase_go <= fire;
         if (!cs_s) begin
            fs         <= FS_IDLE;
            cnt        <= '0;
            rd_active  <= 1'b0;
            erase_pend <= 1'b0;
         end else if (sck_rise) begin
            unique case (fs)
               FS_IDLE: begin
                  if (di_s && !busy) begin
                     fs  <= FS_OPC;
                     cnt <= '0;
                  end
               end
               FS_OPC: begin
                  op <= sme_op_e'({op[0], di_s});
                  if (cnt == CW'(1)) begin
                     fs  <= FS_ADDR;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FS_ADDR: begin
                  addr_sr <= look_addr;
                  if (cnt == CW'(ADDR_W - 1)) begin
                     cnt <= '0;
                     case (op)
                        OP_ERASE: begin
                           erase_pend <= 1'b1;
                           fs         <= FS_DONE;
                        end
                        OP_READ: begin
                           rd_sr     <= {1'b0, rd_word};
                           rd_active <= 1'b1;
                           fs        <= FS_RD;
                        end
                        default: fs <= FS_DONE;
                     endcase
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FS_RD: begin
                  if (cnt == CW'(DATA_W)) begin
                     rd_active <= 1'b0;
                     fs        <= FS_DONE;
                  end else begin
                     rd_sr <= {rd_sr[DATA_W-1:0], 1'b0};
                     cnt   <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R10: the erase timer is never asked to start while it is running
   assert_go_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |-> !busy);

   // R5: each erase request lasts a single system clock
   assert_go_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |=> !erase_go);

endmodule

// File: rtl/sme_erase_timer.sv
module sme_erase_timer #(
   parameter int ERASE_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy,
   output logic wr
);

   localparam int TW = $clog2(ERASE_CYCLES + 1);

   logic [TW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         wr     <= 1'b0;
         remain <= '0;
      end else begin
         wr <= 1'b0;
         if (go && !busy) begin
            busy   <= 1'b1;
            remain <= TW'(ERASE_CYCLES - 1);
         end else if (busy) begin
            if (remain == '0) begin
               busy <= 1'b0;
               wr   <= 1'b1;
            end else begin
               remain <= remain - 1'b1;
            end
         end
      end
   end

   // R7: the word is committed exactly when the busy phase ends
   assert_busy_end_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> wr);

   assert_wr_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> !busy);

endmodule

// File: rtl/sme_word_array.sv
module sme_word_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(3 * i + 1);
      end else if (wr) begin
         mem[waddr] <= '1;
      end
   end

   assign rdata = mem[raddr];

   // R4: an erased word reads as all ones after the commit
   assert_erase_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (mem[$past(waddr)] == {DATA_W{1'b1}}));

endmodule

// File: rtl/sme_erase_ctrl.sv
module sme_erase_ctrl #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 16,
   parameter int ERASE_CYCLES = 1000,
   parameter int CSL_MIN      = 8,
   parameter bit START_ON_CLK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic sdo_o,
   output logic sdo_oe_o
);

   localparam int LW = $clog2(CSL_MIN + 1);

   initial begin
      assert (ADDR_W >= 2) else $error("ADDR_W must be at least 2");
      assert (DATA_W > ADDR_W + 2) else $error("DATA_W too narrow for the reset pattern");
      assert (ERASE_CYCLES >= 1) else $error("ERASE_CYCLES must be positive");
      assert (CSL_MIN >= 1) else $error("CSL_MIN must be positive");
   end

   logic cs_s, di_s, sck_rise, cs_rise, cs_fall;
   logic busy, wr, erase_go, rd_active, rd_bit, start_seen;
   logic [ADDR_W-1:0] look_addr, erase_addr;
   logic [DATA_W-1:0] rd_word;
   logic [LW-1:0]     low_cnt;
   logic              armed, shown, clr_pend;

   sme_pin_sync #(.SYNC_STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_i(sel_i), .sck_i(sclk_i), .di_i(sdi_i),
      .cs_o(cs_s), .di_o(di_s), .sck_rise_o(sck_rise),
      .cs_rise_o(cs_rise), .cs_fall_o(cs_fall)
   );

   sme_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .START_ON_CLK(START_ON_CLK)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .di_s(di_s), .sck_rise(sck_rise),
      .cs_fall(cs_fall), .busy(busy), .rd_word(rd_word),
      .look_addr(look_addr), .erase_addr(erase_addr), .erase_go(erase_go),
      .rd_active(rd_active), .rd_bit(rd_bit), .start_seen(start_seen)
   );

   sme_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .go(erase_go), .busy(busy), .wr(wr)
   );

   sme_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n), .wr(wr), .waddr(erase_addr),
      .raddr(look_addr), .rdata(rd_word)
   );

   // status window: low-time measurement, arming and clearing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         armed    <= 1'b0;
         shown    <= 1'b0;
         clr_pend <= 1'b0;
      end else begin
         if (!cs_s) begin
            if (low_cnt != LW'(CSL_MIN)) low_cnt <= low_cnt + 1'b1;
         end else begin
            low_cnt <= '0;
         end

         if (cs_fall)      shown <= 1'b0;
         else if (cs_rise) shown <= armed && (low_cnt == LW'(CSL_MIN));

         if (erase_go)        clr_pend <= 1'b0;
         else if (start_seen) clr_pend <= 1'b1;
         else if (cs_fall)    clr_pend <= 1'b0;

         if (erase_go)                           armed <= 1'b1;
         else if (cs_fall && clr_pend && !busy)  armed <= 1'b0;
      end
   end

   assign sdo_o    = rd_active ? rd_bit : ~busy;
   assign sdo_oe_o = rd_active | shown;

   // R12: the output is released whenever chip select has stayed low
   assert_hiz_cs_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && $past(!cs_s)) |-> !sdo_oe_o);

   // R8: the status window only opens after a long enough low phase
   assert_short_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && (low_cnt != LW'(CSL_MIN))) |=> !shown);

endmodule

// File: tb/tb_sme_erase_ctrl.sv
`timescale 1ns/1ps
module tb_sme_erase_ctrl;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int EC = 200;
   localparam int CL = 6;
   localparam int NW = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sck = 1'b0, di = 1'b0;
   logic do0, oe0, do1, oe1;
   int   nchk = 0, nfail = 0;
   bit   done = 1'b0;
   logic [DW-1:0] expw [NW];

   always #2 clk = ~clk;

   sme_erase_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(EC), .CSL_MIN(CL),
                    .START_ON_CLK(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .sel_i(cs), .sclk_i(sck), .sdi_i(di),
      .sdo_o(do0), .sdo_oe_o(oe0));

   sme_erase_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(EC), .CSL_MIN(CL),
                    .START_ON_CLK(1'b1)) dut_alt (
      .clk(clk), .rst_n(rst_n), .sel_i(cs), .sclk_i(sck), .sdi_i(di),
      .sdo_o(do1), .sdo_oe_o(oe1));

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic b);
      di = b; wt(4); sck = 1'b1; wt(4); sck = 1'b0;
   endtask

   task automatic hdr(input logic [1:0] op, input int a, input int zeros);
      cs = 1'b1;
      for (int z = 0; z < zeros; z++) sbit(1'b0);
      sbit(1'b1); sbit(op[1]); sbit(op[0]);
      for (int k = AW - 1; k >= 0; k--) sbit(a[k]);
   endtask

   task automatic cs_pulse(input int low);
      cs = 1'b0; wt(low); cs = 1'b1; wt(6);
   endtask

   // read one word on both DUTs; idle=1 also checks the release
   task automatic rd(input int a, input int zeros, input bit idle);
      logic [DW-1:0] g0, g1;
      hdr(2'b10, a, zeros);
      chk("R3 dummy dut", {oe0, do0}, 2);
      chk("R3 dummy dut_alt", {oe1, do1}, 2);
      for (int k = DW - 1; k >= 0; k--) begin
         sbit(1'b0);
         g0[k] = do0; g1[k] = do1;
      end
      chk("R4 read dut", g0, expw[a]);
      chk("R4 read dut_alt", g1, expw[a]);
      if (idle) begin
         sbit(1'b0);
         chk("R3 release", {oe0, oe1}, 0);
      end
      cs = 1'b0; wt(10);
   endtask

   task automatic erase_wait(input int a);
      hdr(2'b11, a, 0);
      cs = 1'b0; wt(EC + 40);
      cs = 1'b1; wt(6);
      chk("R7 ready dut", {oe0, do0}, 3);
      chk("R7 ready dut_alt", {oe1, do1}, 3);
      expw[a] = '1;
      cs = 1'b0; wt(10);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) expw[i] = DW'(3 * i + 1);
      wt(5); rst_n = 1'b1; wt(4);
      chk("R1 reset oe", {oe0, oe1}, 0);

      // R1 R2 R3: full readback of the reset pattern, leading zeros on even
      for (int a = 0; a < NW; a++) rd(a, (a % 2 == 0) ? 2 : 0, 1'b1);

      // R11: unused opcodes leave output off and memory intact
      hdr(2'b01, 5, 0); sbit(1'b0);
      chk("R11 op01 oe", {oe0, oe1}, 0);
      cs = 1'b0; wt(10);
      hdr(2'b00, 5, 0); sbit(1'b0);
      chk("R11 op00 oe", {oe0, oe1}, 0);
      cs = 1'b0; wt(10);
      cs_pulse(10);
      chk("R12 no status", {oe0, oe1}, 0);
      cs = 1'b0; wt(10);
      rd(5, 0, 1'b1);

      // R5 R6: erase word 3, keep chip select high well beyond the erase time
      hdr(2'b11, 3, 0);
      wt(EC + 50);
      cs_pulse(10);
      chk("R5 busy after cs fall dut", {oe0, do0}, 2);
      chk("R6 done before cs fall dut_alt", {oe1, do1}, 3);
      cs = 1'b0; wt(EC + 40);
      cs = 1'b1; wt(6);
      chk("R7 ready dut", {oe0, do0}, 3);
      expw[3] = '1;

      // R8: short low pulse keeps the output released
      cs_pulse(2);
      chk("R8 short low", {oe0, oe1}, 0);
      cs_pulse(10);
      chk("R7 status kept dut", {oe0, do0}, 3);
      chk("R7 status kept dut_alt", {oe1, do1}, 3);

      // R9: start bit then chip select low clears the status
      sbit(1'b1);
      cs_pulse(10);
      chk("R9 cleared", {oe0, oe1}, 0);
      cs = 1'b0; wt(10);

      // R10: erase 6, then try to erase 9 while busy
      hdr(2'b11, 6, 0);
      cs_pulse(10);
      chk("R7 busy dut", {oe0, do0}, 2);
      chk("R7 busy dut_alt", {oe1, do1}, 2);
      sbit(1'b1); sbit(1'b1); sbit(1'b1);
      for (int k = AW - 1; k >= 0; k--) sbit(AW'(9) >> k);
      cs = 1'b0; wt(EC + 40);
      expw[6] = '1;
      cs = 1'b1; wt(6);
      chk("R10 ready after ignored frame", {oe0, do0, oe1, do1}, 15);
      cs = 1'b0; wt(10);
      rd(9, 0, 1'b0);
      rd(6, 0, 1'b0);

      // R4: sweep erase over remaining even addresses, then read all
      for (int a = 0; a < NW; a += 2) if (a != 6) erase_wait(a);
      for (int a = 0; a < NW; a++) rd(a, 0, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule